// File: doc/BRIEF.md
# SECDED Read-Modify-Write Memory Front End

This block sits between a word-addressed client port and a plain memory back end whose words are 40 bits wide: 32 data bits plus 8 check bits. On every write with protection enabled it computes a single-error-correct, double-error-detect code and stores it beside the data. On every read it checks the stored word, corrects a single flipped bit and flags a word that cannot be corrected. A client write that covers only some bytes is turned into a read of the stored word, a byte merge and a full re-encoded write. This keeps the check bits consistent with the data.

After a read whose error could be corrected, the block can repair memory by itself. It issues a fresh read of the same location and then writes the corrected word, so the repair works on current contents. Uncorrectable errors are never written back. The block logs them instead: the address of the first one is captured, a saturating counter counts them, and a maskable interrupt is raised.

Both the client request and the client read response use valid/ready. A request is taken only while `req_ready` is high, and the block works on one request at a time. A response stays on the port, unchanged, until `rsp_ready` is seen high at a clock edge. On the memory side, a command holds its fields while `mem_cmd_ready` is low. The back end returns exactly one `mem_rd_valid` pulse per accepted read, in order, at least one cycle after acceptance. It cannot stall that return.

Top module: `ecc_rmw_front`

## Requirements
- R1: With protection on, a write with all four byte enables set issues exactly one memory write and no read. The write uses mask 5'h1F. The stored word holds the data in bits 31:0 and the check bits in 39:32. Bits 38:0 have even overall parity, and spare bit 39 is zero.
- R2: A read of an intact word returns the written data with status 2'b00 (clean) and issues exactly one memory read.
- R3: A single flipped bit anywhere in bits 38:0 is corrected in the returned data. The status is 2'b01 (corrected).
- R4: Two flipped bits give status 2'b10 (uncorrectable). No memory write follows. The address is logged and the error counter increments.
- R5: With protection on, a write with some but not all byte enables set issues a read of the address and then a write of the same address with mask 5'h1F. The stored data takes enabled bytes from the request and the other bytes from the old word. A pending memory command holds its fields while it is stalled.
- R6: With protection off, any write is one memory write whose mask is {1'b0, byte enables}, with no read. Reads return the raw data bits with status 2'b00.
- R7: With write-back on, a corrected read is followed by one memory read and then one memory write to the same address, which restores the stored word. With write-back off, no further command follows.
- R8: `dbe_irq` is high only while an uncorrectable error is pending and `cfg_dbe_irq_en` is set. A `dbe_irq_clr` pulse clears the pending error.
- R9: `dbe_addr` keeps the first error's address while an error is pending. `dbe_count` saturates at its maximum and never decreases.
- R10: If `dbe_irq_clr` and a new uncorrectable error land on the same clock edge, the error wins: it stays pending and `dbe_addr` takes the new address.
- R11: `req_ready` is low from acceptance until all memory commands for the request are done and any response is taken. The response data and status hold under back-pressure.
- R12: Spare bit 39 is ignored by the check: a flip there reads back clean. With write-back on, it is scrubbed back to zero by a read-then-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ecc_en | input | 1 | Enable check-bit generation and checking |
| cfg_wb_en | input | 1 | Enable automatic corrective write-back |
| cfg_dbe_irq_en | input | 1 | Unmask the uncorrectable-error interrupt |
| dbe_irq_clr | input | 1 | Pulse to clear the pending uncorrectable error |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit n covers data bits 8n+7:8n |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Client accepts the response |
| rsp_rdata | output | 32 | Corrected read data |
| rsp_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Back end takes the command |
| mem_cmd_write | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | AW | Memory word address |
| mem_cmd_wdata | output | 40 | Stored word: check bits 39:32, data 31:0 |
| mem_cmd_mask | output | 5 | Per-byte write mask of the stored word |
| mem_rd_valid | input | 1 | Read data return strobe |
| mem_rd_data | input | 40 | Returned stored word |
| dbe_irq | output | 1 | Uncorrectable-error interrupt |
| dbe_addr | output | AW | Captured address of the first pending error |
| dbe_count | output | CNT_W | Saturating uncorrectable-error count |

## Verification
The error log can be asked to clear the pending error on the same edge at which the sequencer reports a fresh uncorrectable read. The bench provokes this by watching `mem_rd_valid` during a read of a corrupted word and raising `dbe_irq_clr` in that same cycle, while an older error at another address is still pending. The outcome is judged at the ports after the edge: `dbe_irq` must still be high and `dbe_addr` must show the new address. In a separate run, the clear alone must drop the interrupt.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

  localparam int DATA_W  = 32;
  localparam int BYTE_N  = DATA_W / 8;
  localparam int HAM_W   = $clog2(DATA_W) + 1;
  localparam int CHK_W   = 8;
  localparam int CODE_W  = DATA_W + CHK_W;
  localparam int LANE_N  = CODE_W / 8;
  localparam int SPARE_W = CHK_W - HAM_W - 1;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_FATAL = 2'd2
  } ecc_stat_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CMD,
    S_RD_WAIT,
    S_RSP,
    S_WR_CMD
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_READ,
    OP_FULL,
    OP_MERGE,
    OP_SCRUB
  } op_kind_e;

  // Codeword position (1-based, powers of two excluded) of data bit idx
  function automatic int data_pos(input int idx);
    int n;
    int found;
    n = -1;
    found = 0;
    for (int q = 1; q < 128; q++) begin
      if ((q & (q - 1)) != 0) begin
        n++;
        if (n == idx && found == 0) found = q;
      end
    end
    return found;
  endfunction

  // Hamming parity bits over the data bits
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] p;
    int pos;
    p = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pos = data_pos(i);
      for (int k = 0; k < HAM_W; k++) begin
        if (pos[k]) p[k] = p[k] ^ d[i];
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  logic [HAM_W-1:0] ham;
  logic             ovr;

  always_comb begin
    ham = ham_bits(data);
    ovr = (^data) ^ (^ham);
    chk = {{SPARE_W{1'b0}}, ovr, ham};
  end

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_rmw_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output ecc_stat_e         stat,
  output logic              spare_dirty
);

  logic [DATA_W-1:0]  raw;
  logic [HAM_W-1:0]   stored_p;
  logic [HAM_W-1:0]   syn;
  logic               stored_ovr;
  logic               odd;
  logic               hit;
  logic [SPARE_W-1:0] spare;

  always_comb begin
    raw        = code[DATA_W-1:0];
    stored_p   = code[DATA_W +: HAM_W];
    stored_ovr = code[DATA_W + HAM_W];
    spare      = code[CODE_W-1 -: SPARE_W];
    syn        = stored_p ^ ham_bits(raw);
    odd        = (^raw) ^ (^stored_p) ^ stored_ovr;
    data       = raw;
    stat       = ECC_CLEAN;
    hit        = 1'b0;
    if (odd) begin
      stat = ECC_FIXED;
      // syndrome not a power of two: points at a data bit
      if ((syn & (syn - 1'b1)) != '0) begin
        for (int i = 0; i < DATA_W; i++) begin
          if (data_pos(i) == int'(syn)) begin
            data[i] = ~raw[i];
            hit     = 1'b1;
          end
        end
        if (!hit) stat = ECC_FATAL;
      end
    end else if (syn != '0) begin
      stat = ECC_FATAL;
    end
    spare_dirty = |spare;
  end

endmodule

// File: rtl/ecc_dbe_log.sv
module ecc_dbe_log #(
  parameter int AW    = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [AW-1:0]    evt_addr,
  input  logic             clr,
  input  logic             irq_en,
  output logic             irq,
  output logic [AW-1:0]    addr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      addr    <= '0;
      count   <= '0;
    end else begin
      if (evt) pending <= 1'b1;
      else if (clr) pending <= 1'b0;
      if (evt && (!pending || clr)) addr <= evt_addr;
      if (evt && count != CNT_MAX) count <= count + 1'b1;
    end
  end

  assign irq = pending & irq_en;

endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
  import ecc_rmw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ecc_en,
  input  logic              cfg_wb_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BYTE_N-1:0] req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_status,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [AW-1:0]     mem_cmd_addr,
  output logic [CODE_W-1:0] mem_cmd_wdata,
  output logic [LANE_N-1:0] mem_cmd_mask,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_raw,
  output logic [DATA_W-1:0] enc_data,
  input  logic [CHK_W-1:0]  enc_chk,
  input  logic [DATA_W-1:0] dec_data,
  input  ecc_stat_e         dec_stat,
  input  logic              dec_spare,
  output logic              dbe_evt,
  output logic [AW-1:0]     dbe_evt_addr
);

  seq_state_e        state;
  op_kind_e          op_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BYTE_N-1:0] be_q;
  logic              ecc_q;
  logic              wb_q;
  logic              scrub_q;
  logic [DATA_W-1:0] rsp_data_q;
  ecc_stat_e         rsp_stat_q;
  logic [DATA_W-1:0] merged;
  logic              needs_fix;

  // byte-lane merge of request bytes over the corrected old word
  for (genvar b = 0; b < BYTE_N; b++) begin : g_lane
    assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign needs_fix = (dec_stat == ECC_FIXED) || dec_spare;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= OP_READ;
      addr_q     <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      ecc_q      <= 1'b0;
      wb_q       <= 1'b0;
      scrub_q    <= 1'b0;
      rsp_data_q <= '0;
      rsp_stat_q <= ECC_CLEAN;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            ecc_q   <= cfg_ecc_en;
            wb_q    <= cfg_wb_en;
            if (req_write) begin
              if (!cfg_ecc_en || (&req_be)) begin
                op_q  <= OP_FULL;
                state <= S_WR_CMD;
              end else begin
                op_q  <= OP_MERGE;
                state <= S_RD_CMD;
              end
            end else begin
              op_q  <= OP_READ;
              state <= S_RD_CMD;
            end
          end
        end
        S_RD_CMD: begin
          if (mem_cmd_ready) state <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (mem_rd_valid) begin
            case (op_q)
              OP_MERGE: begin
                wdata_q <= merged;
                be_q    <= '1;
                state   <= S_WR_CMD;
              end
              OP_SCRUB: begin
                if (needs_fix) begin
                  wdata_q <= dec_data;
                  be_q    <= '1;
                  state   <= S_WR_CMD;
                end else begin
                  state <= S_IDLE;
                end
              end
              default: begin
                rsp_data_q <= ecc_q ? dec_data : mem_rd_raw;
                rsp_stat_q <= ecc_q ? dec_stat : ECC_CLEAN;
                scrub_q    <= ecc_q && wb_q && needs_fix;
                state      <= S_RSP;
              end
            endcase
          end
        end
        S_RSP: begin
          if (rsp_ready) begin
            if (scrub_q) begin
              op_q  <= OP_SCRUB;
              state <= S_RD_CMD;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_WR_CMD: begin
          if (mem_cmd_ready) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_RSP);
  assign rsp_rdata     = rsp_data_q;
  assign rsp_status    = rsp_stat_q;
  assign mem_cmd_valid = (state == S_RD_CMD) || (state == S_WR_CMD);
  assign mem_cmd_write = (state == S_WR_CMD);
  assign mem_cmd_addr  = addr_q;
  assign enc_data      = wdata_q;
  assign mem_cmd_wdata = ecc_q ? {enc_chk, wdata_q} : {{CHK_W{1'b0}}, wdata_q};
  assign mem_cmd_mask  = ecc_q ? {LANE_N{1'b1}} : {{(LANE_N-BYTE_N){1'b0}}, be_q};
  assign dbe_evt       = (state == S_RD_WAIT) && mem_rd_valid && ecc_q && (dec_stat == ECC_FATAL);
  assign dbe_evt_addr  = addr_q;

endmodule

// File: rtl/ecc_rmw_front.sv
module ecc_rmw_front
  import ecc_rmw_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ecc_en,
  input  logic              cfg_wb_en,
  input  logic              cfg_dbe_irq_en,
  input  logic              dbe_irq_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        rsp_status,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [AW-1:0]     mem_cmd_addr,
  output logic [39:0]       mem_cmd_wdata,
  output logic [4:0]        mem_cmd_mask,
  input  logic              mem_rd_valid,
  input  logic [39:0]       mem_rd_data,
  output logic              dbe_irq,
  output logic [AW-1:0]     dbe_addr,
  output logic [CNT_W-1:0]  dbe_count
);

  logic [DATA_W-1:0] enc_data;
  logic [CHK_W-1:0]  enc_chk;
  logic [DATA_W-1:0] dec_data;
  ecc_stat_e         dec_stat;
  logic              dec_spare;
  logic              dbe_evt;
  logic [AW-1:0]     dbe_evt_addr;

  ecc_enc u_enc (
    .data (enc_data),
    .chk  (enc_chk)
  );

  ecc_dec u_dec (
    .code        (mem_rd_data),
    .data        (dec_data),
    .stat        (dec_stat),
    .spare_dirty (dec_spare)
  );

  ecc_rmw_seq #(.AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ecc_en    (cfg_ecc_en),
    .cfg_wb_en     (cfg_wb_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_be        (req_be),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_rdata     (rsp_rdata),
    .rsp_status    (rsp_status),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_cmd_ready (mem_cmd_ready),
    .mem_cmd_write (mem_cmd_write),
    .mem_cmd_addr  (mem_cmd_addr),
    .mem_cmd_wdata (mem_cmd_wdata),
    .mem_cmd_mask  (mem_cmd_mask),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_raw    (mem_rd_data[DATA_W-1:0]),
    .enc_data      (enc_data),
    .enc_chk       (enc_chk),
    .dec_data      (dec_data),
    .dec_stat      (dec_stat),
    .dec_spare     (dec_spare),
    .dbe_evt       (dbe_evt),
    .dbe_evt_addr  (dbe_evt_addr)
  );

  ecc_dbe_log #(.AW(AW), .CNT_W(CNT_W)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (dbe_evt),
    .evt_addr (dbe_evt_addr),
    .clr      (dbe_irq_clr),
    .irq_en   (cfg_dbe_irq_en),
    .irq      (dbe_irq),
    .addr     (dbe_addr),
    .count    (dbe_count)
  );

endmodule

// File: rtl/ecc_rmw_front_chk.sv
module ecc_rmw_front_chk #(
  parameter int AW    = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic [1:0]       rsp_status,
  input logic             mem_cmd_valid,
  input logic             mem_cmd_ready,
  input logic             mem_cmd_write,
  input logic [AW-1:0]    mem_cmd_addr,
  input logic             mem_cmd_spare,
  input logic             mem_cmd_chk_lane,
  input logic             dbe_irq,
  input logic [CNT_W-1:0] dbe_count
);

  // R11
  req_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_cmd_valid));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_status)));

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_write) && $stable(mem_cmd_addr)));

  // R4
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'b11));

  // R9
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (dbe_count >= $past(dbe_count)));

  // R8
  irq_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbe_count == '0) |-> !dbe_irq);

  // R12
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_write && mem_cmd_chk_lane) |-> !mem_cmd_spare);

endmodule

bind ecc_rmw_front ecc_rmw_front_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_ready        (req_ready),
  .rsp_valid        (rsp_valid),
  .rsp_ready        (rsp_ready),
  .rsp_rdata        (rsp_rdata),
  .rsp_status       (rsp_status),
  .mem_cmd_valid    (mem_cmd_valid),
  .mem_cmd_ready    (mem_cmd_ready),
  .mem_cmd_write    (mem_cmd_write),
  .mem_cmd_addr     (mem_cmd_addr),
  .mem_cmd_spare    (mem_cmd_wdata[39]),
  .mem_cmd_chk_lane (mem_cmd_mask[4]),
  .dbe_irq          (dbe_irq),
  .dbe_count        (dbe_count)
);

// File: tb/ecc_rmw_front_tb_top.sv
`timescale 1ns/1ps
module ecc_rmw_front_tb_top;

  localparam int AW    = 8;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             cfg_ecc_en = 1'b1, cfg_wb_en = 1'b0, cfg_dbe_irq_en = 1'b0, dbe_irq_clr = 1'b0;
  logic             req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [31:0]      req_wdata = '0;
  logic [3:0]       req_be = '0;
  logic             req_ready, rsp_valid;
  logic [31:0]      rsp_rdata;
  logic [1:0]       rsp_status;
  logic             mem_cmd_valid, mem_cmd_write;
  logic             mem_cmd_ready = 1'b1;
  logic [AW-1:0]    mem_cmd_addr;
  logic [39:0]      mem_cmd_wdata;
  logic [4:0]       mem_cmd_mask;
  logic             mem_rd_valid;
  logic [39:0]      mem_rd_data;
  logic             dbe_irq;
  logic [AW-1:0]    dbe_addr;
  logic [CNT_W-1:0] dbe_count;

  ecc_rmw_front #(.AW(AW), .CNT_W(CNT_W)) dut_i (.*);

  // memory back-end model with command log and bit-flip injection
  logic [39:0]   mem [256];
  logic          log_w [256];
  logic [AW-1:0] log_a [256];
  logic [4:0]    log_m [256];
  int            ncmd;
  logic          inj_go = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [39:0]   inj_mask = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      ncmd         <= 0;
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
    end else begin
      mem_rd_valid <= 1'b0;
      if (inj_go) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (mem_cmd_valid && mem_cmd_ready) begin
        log_w[ncmd[7:0]] <= mem_cmd_write;
        log_a[ncmd[7:0]] <= mem_cmd_addr;
        log_m[ncmd[7:0]] <= mem_cmd_mask;
        ncmd <= ncmd + 1;
        if (mem_cmd_write) begin
          for (int b = 0; b < 5; b++)
            if (mem_cmd_mask[b]) mem[mem_cmd_addr][8*b +: 8] <= mem_cmd_wdata[8*b +: 8];
        end else begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= mem[mem_cmd_addr];
        end
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    issue(1'b1, a, d, be);
    wait_idle();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int hold, input bit clr_at_data,
                         output logic [31:0] d, output logic [1:0] s);
    issue(1'b0, a, '0, '0);
    if (clr_at_data) begin
      while (!mem_rd_valid) @(negedge clk);
      dbe_irq_clr = 1'b1;
      @(negedge clk);
      dbe_irq_clr = 1'b0;
    end
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata; s = rsp_status;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_rdata == d && rsp_status == s,
          "R11 response held under back-pressure", {rsp_valid, req_ready, rsp_status}, {1'b1, 1'b0, s});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [39:0] m);
    @(negedge clk);
    inj_addr = a; inj_mask = m; inj_go = 1'b1;
    @(negedge clk);
    inj_go = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !mem_cmd_valid, "R11 reset idle", {req_ready, rsp_valid, mem_cmd_valid}, 3'b100);
    chk(!dbe_irq && dbe_count == 0, "R8 reset no error", {dbe_irq, dbe_count}, 0);
  endtask

  task automatic t_full_write();
    int base;
    base = ncmd;
    do_write(8'd3, 32'hA5A5_1234, 4'hF);
    chk(ncmd - base == 1 && log_w[base[7:0]] && log_m[base[7:0]] == 5'h1F, "R1 single full write",
        {ncmd - base, log_m[base[7:0]]}, {32'd1, 5'h1F});
    chk(mem[3][31:0] == 32'hA5A5_1234 && (^mem[3][38:0]) == 1'b0 && !mem[3][39], "R1 stored layout",
        mem[3], {8'h00, 32'hA5A5_1234});
  endtask

  task automatic t_clean_read();
    logic [31:0] d; logic [1:0] s; int base;
    base = ncmd;
    do_read(8'd3, 0, 1'b0, d, s);
    chk(d == 32'hA5A5_1234 && s == 2'b00, "R2 clean read", {d, s}, {32'hA5A5_1234, 2'b00});
    chk(ncmd - base == 1, "R2 one read command", ncmd - base, 1);
  endtask

  task automatic t_single();
    logic [31:0] d; logic [1:0] s; int base;
    int bits [5] = '{0, 17, 31, 34, 38};
    cfg_wb_en = 1'b0;
    do_write(8'd7, 32'h0F1E_2D3C, 4'hF);
    foreach (bits[i]) begin
      inject(8'd7, 40'd1 << bits[i]);
      base = ncmd;
      do_read(8'd7, 0, 1'b0, d, s);
      chk(d == 32'h0F1E_2D3C && s == 2'b01, "R3 single flip corrected", {d, s}, {32'h0F1E_2D3C, 2'b01});
      chk(ncmd - base == 1, "R7 no write-back when disabled", ncmd - base, 1);
      inject(8'd7, 40'd1 << bits[i]);
    end
  endtask

  task automatic t_writeback();
    logic [31:0] d; logic [1:0] s; logic [39:0] snap; int base;
    cfg_wb_en = 1'b1;
    do_write(8'd9, 32'hCAFE_F00D, 4'hF);
    snap = mem[9];
    inject(8'd9, 40'd1 << 12);
    base = ncmd;
    do_read(8'd9, 0, 1'b0, d, s);
    chk(d == 32'hCAFE_F00D && s == 2'b01, "R7 corrected read", {d, s}, {32'hCAFE_F00D, 2'b01});
    chk(ncmd - base == 3 && !log_w[base[7:0]] && !log_w[8'(base + 1)] && log_w[8'(base + 2)]
        && log_a[8'(base + 1)] == 8'd9 && log_a[8'(base + 2)] == 8'd9,
        "R7 read then write to same address", ncmd - base, 3);
    chk(mem[9] == snap, "R7 stored word restored", mem[9], snap);
  endtask

  task automatic t_double();
    logic [31:0] d; logic [1:0] s; int base; logic [CNT_W-1:0] c0;
    cfg_wb_en = 1'b1; cfg_dbe_irq_en = 1'b1;
    c0 = dbe_count;
    do_write(8'd12, 32'h1357_9BDF, 4'hF);
    inject(8'd12, 40'h0000_0000_21);
    base = ncmd;
    do_read(8'd12, 0, 1'b0, d, s);
    chk(s == 2'b10 && ncmd - base == 1, "R4 uncorrectable, no write", {s, ncmd - base}, {2'b10, 32'd1});
    chk(dbe_addr == 8'd12 && dbe_count == c0 + 1 && dbe_irq, "R4 logged",
        {dbe_addr, dbe_count, dbe_irq}, {8'd12, c0 + 4'd1, 1'b1});
  endtask

  task automatic t_irq();
    cfg_dbe_irq_en = 1'b0;
    @(negedge clk);
    chk(!dbe_irq, "R8 masked", dbe_irq, 0);
    cfg_dbe_irq_en = 1'b1;
    @(negedge clk);
    chk(dbe_irq, "R8 unmasked", dbe_irq, 1);
    dbe_irq_clr = 1'b1;
    @(negedge clk);
    dbe_irq_clr = 1'b0;
    chk(!dbe_irq, "R8 cleared", dbe_irq, 0);
  endtask

  task automatic t_hold_first();
    logic [31:0] d; logic [1:0] s; logic [CNT_W-1:0] c0;
    do_write(8'd20, 32'h2020_2020, 4'hF);
    do_write(8'd21, 32'h2121_2121, 4'hF);
    inject(8'd20, 40'h3); inject(8'd21, 40'h3);
    c0 = dbe_count;
    do_read(8'd20, 0, 1'b0, d, s);
    do_read(8'd21, 0, 1'b0, d, s);
    chk(dbe_addr == 8'd20 && dbe_count == c0 + 2, "R9 first address held",
        {dbe_addr, dbe_count}, {8'd20, c0 + 4'd2});
  endtask

  task automatic t_same_cycle();
    logic [31:0] d; logic [1:0] s;
    do_write(8'd22, 32'h2222_2222, 4'hF);
    inject(8'd22, 40'h6);
    do_read(8'd22, 0, 1'b1, d, s);
    chk(dbe_irq && dbe_addr == 8'd22, "R10 new error wins over clear", {dbe_irq, dbe_addr}, {1'b1, 8'd22});
  endtask

  task automatic t_saturate();
    logic [31:0] d; logic [1:0] s;
    do_write(8'd60, 32'h6060_6060, 4'hF);
    inject(8'd60, 40'h3);
    for (int i = 0; i < 20 && dbe_count != 4'hF; i++) do_read(8'd60, 0, 1'b0, d, s);
    do_read(8'd60, 0, 1'b0, d, s);
    chk(dbe_count == 4'hF, "R9 count saturates", dbe_count, 4'hF);
  endtask

  task automatic t_partial();
    logic [31:0] d; logic [1:0] s; int base;
    cfg_wb_en = 1'b0;
    do_write(8'd30, 32'h1122_3344, 4'hF);
    base = ncmd;
    mem_cmd_ready = 1'b0;
    issue(1'b1, 8'd30, 32'hAABB_CCDD, 4'b0101);
    repeat (3) begin
      @(negedge clk);
      chk(mem_cmd_valid && !mem_cmd_write && !req_ready, "R5 read held while stalled",
          {mem_cmd_valid, mem_cmd_write}, 2'b10);
    end
    mem_cmd_ready = 1'b1;
    wait_idle();
    chk(ncmd - base == 2 && !log_w[base[7:0]] && log_w[8'(base + 1)] && log_a[base[7:0]] == 8'd30
        && log_a[8'(base + 1)] == 8'd30 && log_m[8'(base + 1)] == 5'h1F,
        "R5 read then full-mask write", ncmd - base, 2);
    do_read(8'd30, 2, 1'b0, d, s);
    chk(d == 32'h11BB_33DD && s == 2'b00, "R5 merged word", {d, s}, {32'h11BB_33DD, 2'b00});
  endtask

  task automatic t_ecc_off();
    logic [31:0] d; logic [1:0] s; int base;
    cfg_ecc_en = 1'b0;
    do_write(8'd40, 32'h0000_0000, 4'hF);
    base = ncmd;
    do_write(8'd40, 32'h5566_7788, 4'b0011);
    chk(ncmd - base == 1 && log_w[base[7:0]] && log_m[base[7:0]] == 5'h03, "R6 masked write, no read",
        {ncmd - base, log_m[base[7:0]]}, {32'd1, 5'h03});
    inject(8'd40, 40'h1_0000);
    do_read(8'd40, 0, 1'b0, d, s);
    chk(d == 32'h0001_7788 && s == 2'b00, "R6 raw read", {d, s}, {32'h0001_7788, 2'b00});
    cfg_ecc_en = 1'b1;
  endtask

  task automatic t_spare();
    logic [31:0] d; logic [1:0] s; int base;
    cfg_wb_en = 1'b1;
    do_write(8'd50, 32'h89AB_CDEF, 4'hF);
    inject(8'd50, 40'h80_0000_0000);
    base = ncmd;
    do_read(8'd50, 0, 1'b0, d, s);
    chk(d == 32'h89AB_CDEF && s == 2'b00, "R12 spare bit ignored", {d, s}, {32'h89AB_CDEF, 2'b00});
    chk(ncmd - base == 3 && !mem[50][39], "R12 spare bit scrubbed", {ncmd - base, mem[50][39]}, {32'd3, 1'b0});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_clean_read();
    t_single();
    t_writeback();
    t_double();
    t_irq();
    t_hold_first();
    t_same_cycle();
    t_partial();
    t_ecc_off();
    t_spare();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

endmodule